// File: doc/BRIEF.md
# Programmable Countdown Interrupt Timer

This block is a periodic interrupt source built around a down-counter that software programs through a small register interface. It halves the system clock and divides it again by a power of two chosen by a 4-bit prescaler field. Each divided tick lowers the count by one. The tick on which the count leaves zero is an underflow. An underflow sets a sticky flag, and the counter then either reloads from a modulus register or wraps to all ones.

Software reaches three word registers: a control/status register, a modulus register and a read-only count register. Writes honour byte lanes. A write to the modulus register normally reaches the counter only at the next reload. If the overwrite bit is set, the write loads the counter at once. Any write that touches the byte holding the prescaler field restarts counting, even when it writes the same value. This is why software must use low-byte-only writes to set or clear the other control bits without losing time.

Two halt inputs, one for a low-power doze state and one for a debug stop, can freeze the timer, each only if its own control bit allows it. A single level interrupt request goes to the interrupt controller.

Top module: `cdt_timer`

## Requirements
- R1: After reset the control register reads 0, the modulus and count registers read 0xFFFF, and `irqReq` is low.
- R2: Register map, by word address on `busAddr`: 0 is control, 1 is modulus, 2 is count. Control bits are: enable bit 0, reload bit 1, flag bit 2, interrupt-enable bit 3, overwrite bit 4, debug-halt bit 5, doze-halt bit 6, prescaler PRE in bits 11:8. While enabled, the count drops by one every 2^(PRE+1) clocks. With reload set, underflows repeat every 2^(PRE+1)·(M+1) clocks, where M is the modulus, and the count reads M right after each underflow.
- R3: With reload clear, the counter wraps from 0 to 0xFFFF on underflow, and the flag is still set.
- R4: A modulus write with overwrite clear leaves the current count untouched, so counting goes on from the old value. The new modulus is used at the next reload.
- R5: A modulus write with overwrite set loads the counter with the written value on the next clock and restarts the prescaler and the half-clock phase.
- R6: A control write with byte lane 1 enabled sets the count to 0xFFFF and restarts the prescaler, even if PRE is unchanged. A write with only lane 0 enabled leaves the count, the timing and the PRE field unchanged.
- R7: The flag is cleared by writing 1 to bit 2 through lane 0. Writing 0 there has no effect. If a clear and an underflow fall in the same cycle, the flag stays set.
- R8: `irqReq` is high exactly when the flag and interrupt-enable are both set.
- R9: Clearing enable freezes the count and the prescaler. Setting it again resumes counting from the frozen state.
- R10: While doze-halt is set and `dozeMode` is high, counting is frozen. The same holds for debug-halt and `debugMode`. A mode input whose halt bit is clear has no effect.
- R11: Modulus writes update only the byte lanes enabled in `busByteEn`. Writes to the count register are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrEn | input | 1 | Write strobe, sampled on the rising clock edge |
| busAddr | input | 2 | Word address of the register accessed |
| busWrData | input | 16 | Write data |
| busByteEn | input | 2 | Byte-lane enables for the write |
| busRdData | output | 16 | Read data, combinational from busAddr |
| dozeMode | input | 1 | Chip is in the doze state |
| debugMode | input | 1 | Chip is halted for debug |
| irqReq | output | 1 | Level interrupt request |

## Verification
The assertions check the following on every cycle: the interrupt request matches flag AND interrupt-enable as read on the bus, and the count only ever steps down by one between writes. They also check that an underflow sets the flag and that a wrap without reload lands on all ones. Further per-cycle checks cover the freezes (disable, doze halt, writes to the count register), immediate loads under overwrite, and the all-ones restart on a prescaler-byte write. The exact period for each prescaler and modulus pair can only be shown by the bench's scenarios, and so can the clock in which the first decrement lands after a restart. The same goes for the rule that a low-byte write leaves an underflow on its original cycle, and for a flag clear that coincides with an underflow.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  localparam int PRE_W = 4;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_MOD  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CNT  = 2'd2;

  localparam int BIT_EN   = 0;
  localparam int BIT_RLD  = 1;
  localparam int BIT_FLAG = 2;
  localparam int BIT_IE   = 3;
  localparam int BIT_OVW  = 4;
  localparam int BIT_DBG  = 5;
  localparam int BIT_DOZE = 6;
  localparam int PRE_LSB  = 8;

  typedef struct packed {
    logic [PRE_W-1:0] pre;
    logic dozeHalt;
    logic debugHalt;
    logic overwrite;
    logic irqEn;
    logic reload;
    logic enable;
  } cdt_cfg_t;

  // strobes from control to datapath
  typedef struct packed {
    logic tick;
    logic restart;
    logic loadNow;
    logic flagClr;
    logic reload;
  } cdt_strb_t;
endpackage

// File: rtl/cdt_ctrl.sv
module cdt_ctrl
  import cdt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      busWrEn,
  input  logic [ADDR_W-1:0]         busAddr,
  input  logic [CNT_W-1:0]          busWrData,
  input  logic [CNT_W/8-1:0]        busByteEn,
  input  logic                      dozeMode,
  input  logic                      debugMode,
  output cdt_cfg_t                  cfgQ,
  output cdt_strb_t                 strb,
  output logic [CNT_W/8-1:0]        modLaneWr
);
  localparam int LANES = CNT_W / 8;
  localparam int DIV_W = (1 << PRE_W) - 1;

  logic wrCtrl, wrLo, wrHi, wrMod;
  logic running, presClr;
  logic phaseQ;
  logic [DIV_W-1:0] divQ;
  logic [DIV_W-1:0] divLimit;
  logic unusedData;

  assign wrCtrl = busWrEn && (busAddr == ADDR_CTRL);
  assign wrLo   = wrCtrl && busByteEn[0];
  assign wrHi   = wrCtrl && busByteEn[1];
  assign wrMod  = busWrEn && (busAddr == ADDR_MOD);

  assign unusedData = ^{busWrData[CNT_W-1:PRE_LSB+PRE_W], busWrData[7]};

  generate
    for (genvar i = 0; i < LANES; i++) begin : gLane
      assign modLaneWr[i] = wrMod && busByteEn[i];
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ <= '0;
    end else begin
      if (wrLo) begin
        cfgQ.enable    <= busWrData[BIT_EN];
        cfgQ.reload    <= busWrData[BIT_RLD];
        cfgQ.irqEn     <= busWrData[BIT_IE];
        cfgQ.overwrite <= busWrData[BIT_OVW];
        cfgQ.debugHalt <= busWrData[BIT_DBG];
        cfgQ.dozeHalt  <= busWrData[BIT_DOZE];
      end
      if (wrHi) begin
        cfgQ.pre <= busWrData[PRE_LSB +: PRE_W];
      end
    end
  end

  assign running = cfgQ.enable
                && !(cfgQ.dozeHalt && dozeMode)
                && !(cfgQ.debugHalt && debugMode);
  assign presClr = wrHi || (wrMod && cfgQ.overwrite);
  assign divLimit = ~({DIV_W{1'b1}} << cfgQ.pre);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseQ <= 1'b0;
      divQ   <= '0;
    end else if (presClr) begin
      phaseQ <= 1'b0;
      divQ   <= '0;
    end else if (running) begin
      phaseQ <= ~phaseQ;
      if (phaseQ) begin
        divQ <= (divQ == divLimit) ? '0 : divQ + 1'b1;
      end
    end
  end

  always_comb begin
    strb.tick    = running && phaseQ && (divQ == divLimit) && !presClr;
    strb.restart = wrHi;
    strb.loadNow = wrMod && cfgQ.overwrite;
    strb.flagClr = wrLo && busWrData[BIT_FLAG];
    strb.reload  = cfgQ.reload;
  end
endmodule

// File: rtl/cdt_datapath.sv
module cdt_datapath
  import cdt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [CNT_W-1:0]    busWrData,
  input  logic [CNT_W/8-1:0]  modLaneWr,
  input  cdt_strb_t           strb,
  output logic [CNT_W-1:0]    modQ,
  output logic [CNT_W-1:0]    cntQ,
  output logic                flagQ
);
  localparam int LANES = CNT_W / 8;

  logic [CNT_W-1:0] modNext;
  logic underflow;

  generate
    for (genvar i = 0; i < LANES; i++) begin : gMerge
      assign modNext[8*i +: 8] = modLaneWr[i] ? busWrData[8*i +: 8] : modQ[8*i +: 8];
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) modQ <= '1;
    else       modQ <= modNext;
  end

  assign underflow = strb.tick && (cntQ == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= '1;
    end else if (strb.restart) begin
      cntQ <= '1;
    end else if (strb.loadNow) begin
      cntQ <= modNext;
    end else if (strb.tick) begin
      if (cntQ == '0) cntQ <= strb.reload ? modQ : '1;
      else            cntQ <= cntQ - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flagQ <= 1'b0;
    else       flagQ <= underflow || (flagQ && !strb.flagClr);
  end
endmodule

// File: rtl/cdt_timer.sv
module cdt_timer
  import cdt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busWrEn,
  input  logic [1:0]          busAddr,
  input  logic [CNT_W-1:0]    busWrData,
  input  logic [CNT_W/8-1:0]  busByteEn,
  output logic [CNT_W-1:0]    busRdData,
  input  logic                dozeMode,
  input  logic                debugMode,
  output logic                irqReq
);
  cdt_cfg_t cfgQ;
  cdt_strb_t strb;
  logic [CNT_W/8-1:0] modLaneWr;
  logic [CNT_W-1:0] modQ, cntQ;
  logic flagQ;

  cdt_ctrl #(.CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busByteEn(busByteEn), .dozeMode(dozeMode),
    .debugMode(debugMode), .cfgQ(cfgQ), .strb(strb), .modLaneWr(modLaneWr)
  );

  cdt_datapath #(.CNT_W(CNT_W)) uDp (
    .clk(clk), .rstN(rstN), .busWrData(busWrData), .modLaneWr(modLaneWr),
    .strb(strb), .modQ(modQ), .cntQ(cntQ), .flagQ(flagQ)
  );

  always_comb begin
    busRdData = '0;
    unique case (busAddr)
      ADDR_CTRL: begin
        busRdData[BIT_EN]               = cfgQ.enable;
        busRdData[BIT_RLD]              = cfgQ.reload;
        busRdData[BIT_FLAG]             = flagQ;
        busRdData[BIT_IE]               = cfgQ.irqEn;
        busRdData[BIT_OVW]              = cfgQ.overwrite;
        busRdData[BIT_DBG]              = cfgQ.debugHalt;
        busRdData[BIT_DOZE]             = cfgQ.dozeHalt;
        busRdData[PRE_LSB +: PRE_W]     = cfgQ.pre;
      end
      ADDR_MOD: busRdData = modQ;
      ADDR_CNT: busRdData = cntQ;
      default:  busRdData = '0;
    endcase
  end

  assign irqReq = flagQ && cfgQ.irqEn;
endmodule

// File: rtl/cdt_checker.sv
module cdt_checker
  import cdt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic               clk,
  input logic               rstN,
  input logic               busWrEn,
  input logic [1:0]         busAddr,
  input logic [CNT_W-1:0]   busWrData,
  input logic [CNT_W/8-1:0] busByteEn,
  input logic [CNT_W-1:0]   busRdData,
  input logic               irqReq,
  input logic               dozeMode,
  input cdt_cfg_t           cfg,
  input logic               tick,
  input logic [CNT_W-1:0]   cntQ,
  input logic               flagQ
);
  AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == ADDR_CTRL) |-> (irqReq == (busRdData[BIT_FLAG] && busRdData[BIT_IE]))); // R8

  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rstN)
    (!busWrEn && cntQ != '0) |=> (cntQ == $past(cntQ) || cntQ == $past(cntQ) - 1'b1)); // R2

  AST_WRAP_NO_RELOAD: assert property (@(posedge clk) disable iff (!rstN)
    (tick && cntQ == '0 && !cfg.reload && !busWrEn) |=> (cntQ == '1)); // R3

  AST_OVW_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == ADDR_MOD && cfg.overwrite && (&busByteEn)) |=> (cntQ == $past(busWrData))); // R5

  AST_PRE_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == ADDR_CTRL && busByteEn[1]) |=> (cntQ == '1)); // R6

  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rstN)
    (tick && cntQ == '0) |=> flagQ); // R7

  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == ADDR_CTRL && busByteEn[0] && busWrData[BIT_FLAG] && !(tick && cntQ == '0)) |=> !flagQ); // R7

  AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (!rstN)
    (!cfg.enable && !busWrEn) |=> $stable(cntQ)); // R9

  AST_DOZE_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.dozeHalt && dozeMode && !busWrEn) |=> $stable(cntQ)); // R10

  AST_CNT_READ_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == ADDR_CNT && !tick) |=> $stable(cntQ)); // R11
endmodule

bind cdt_timer cdt_checker #(.CNT_W(CNT_W)) uChk (
  .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
  .busWrData(busWrData), .busByteEn(busByteEn), .busRdData(busRdData),
  .irqReq(irqReq), .dozeMode(dozeMode), .cfg(cfgQ), .tick(strb.tick),
  .cntQ(cntQ), .flagQ(flagQ)
);

// File: tb/cdt_timer_test.sv
module cdt_timer_test;
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_MOD  = 2'd1;
  localparam logic [1:0] A_CNT  = 2'd2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWrEn = 1'b0;
  logic [1:0] busAddr = 2'd0;
  logic [15:0] busWrData = '0;
  logic [1:0] busByteEn = '0;
  logic [15:0] busRdData;
  logic dozeMode = 1'b0;
  logic debugMode = 1'b0;
  logic irqReq;

  int checkCount = 0;
  int failCount = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  cdt_timer uut (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busByteEn(busByteEn), .busRdData(busRdData),
    .dozeMode(dozeMode), .debugMode(debugMode), .irqReq(irqReq)
  );

  function automatic logic [15:0] ctrlWord(input int pre, input bit doze, input bit dbg,
      input bit ovw, input bit ie, input bit flag, input bit rld, input bit en);
    logic [15:0] w;
    w = '0;
    w[11:8] = pre[3:0];
    w[6] = doze; w[5] = dbg; w[4] = ovw; w[3] = ie; w[2] = flag; w[1] = rld; w[0] = en;
    return w;
  endfunction

  function automatic int periodOf(input int m, input int pre);
    return (2 << pre) * (m + 1);
  endfunction

  function automatic int countAfter(input int m, input int pre, input int k);
    return m - k / (2 << pre);
  endfunction

  task automatic busWrite(input logic [1:0] a, input logic [15:0] d, input logic [1:0] be);
    busWrEn = 1'b1; busAddr = a; busWrData = d; busByteEn = be;
    @(negedge clk);
    busWrEn = 1'b0; busByteEn = '0;
  endtask

  task automatic readReg(input logic [1:0] a, output logic [15:0] v);
    busAddr = a;
    #1;
    v = busRdData;
  endtask

  task automatic waitEdges(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic checkEq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic checkCnt(input string tag, input int exp);
    logic [15:0] v;
    readReg(A_CNT, v);
    checkEq(tag, {16'd0, v}, exp);
  endtask

  task automatic checkFlag(input string tag, input bit exp);
    logic [15:0] v;
    readReg(A_CTRL, v);
    checkEq(tag, {31'd0, v[2]}, {31'd0, exp});
  endtask

  // configure stopped, load modulus with overwrite, then enable (low byte only)
  task automatic armTimer(input int pre, input int m, input bit ie, input bit rld,
                          input bit doze, input bit dbg);
    busWrite(A_CTRL, ctrlWord(pre, doze, dbg, 1'b1, ie, 1'b1, rld, 1'b0), 2'b11);
    busWrite(A_MOD, m[15:0], 2'b11);
    busWrite(A_CTRL, ctrlWord(pre, doze, dbg, 1'b0, ie, 1'b0, rld, 1'b1), 2'b01);
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      failCount++;
      checkCount++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    void'($urandom(32'd2024));
    waitEdges(3);
    rstN = 1'b1;
    waitEdges(1);

    // R1 reset state
    readReg(A_CTRL, v); checkEq("R1 ctrl", {16'd0, v}, 32'h0);
    readReg(A_MOD, v);  checkEq("R1 modulus", {16'd0, v}, 32'hFFFF);
    checkCnt("R1 count", 16'hFFFF);
    checkEq("R1 irq", {31'd0, irqReq}, 32'd0);

    // R4 modulus write without overwrite keeps the count at all ones
    busWrite(A_MOD, 16'd5, 2'b11);
    checkCnt("R4 count after plain modulus write", 16'hFFFF);
    readReg(A_MOD, v); checkEq("R4 modulus readback", {16'd0, v}, 32'd5);
    busWrite(A_CTRL, ctrlWord(0, 0, 0, 0, 0, 0, 1, 1), 2'b01);
    waitEdges(2);
    checkCnt("R4 first decrement from all ones", 16'hFFFE);
    busWrite(A_CTRL, 16'h0000, 2'b01);

    // R4 new modulus used at next reload only
    armTimer(0, 1, 1'b0, 1'b1, 1'b0, 1'b0);
    busWrite(A_MOD, 16'd7, 2'b11);
    checkCnt("R4 count kept", 1);
    waitEdges(1);
    checkCnt("R4 count steps", 0);
    waitEdges(2);
    checkCnt("R4 reload uses new modulus", 7);
    checkFlag("R4 flag on underflow", 1'b1);

    // R3 wrap without reload
    armTimer(0, 2, 1'b0, 1'b0, 1'b0, 1'b0);
    waitEdges(5);
    checkCnt("R3 at zero", 0);
    checkFlag("R3 flag before wrap", 1'b0);
    waitEdges(1);
    checkCnt("R3 wrap to all ones", 16'hFFFF);
    checkFlag("R3 flag on wrap", 1'b1);
    waitEdges(2);
    checkCnt("R3 continues", 16'hFFFE);

    // R6 low-byte write keeps timing, high-byte write restarts
    armTimer(0, 9, 1'b0, 1'b1, 1'b0, 1'b0);
    waitEdges(6);
    checkCnt("R6 before low write", 6);
    busWrite(A_CTRL, ctrlWord(0, 0, 0, 0, 0, 0, 1, 1), 2'b01);
    checkCnt("R6 after low write", 6);
    waitEdges(12);
    checkFlag("R6 no early underflow", 1'b0);
    waitEdges(1);
    checkFlag("R6 underflow on original cycle", 1'b1);
    checkCnt("R6 reloaded", 9);
    busWrite(A_CTRL, ctrlWord(0, 0, 0, 0, 0, 0, 1, 1), 2'b10);
    checkCnt("R6 same-value prescaler write restarts", 16'hFFFF);
    waitEdges(1);
    checkCnt("R6 phase restarted", 16'hFFFF);
    waitEdges(1);
    checkCnt("R6 first tick after restart", 16'hFFFE);

    // R7 and R8 flag clearing and interrupt gating
    armTimer(0, 3, 1'b0, 1'b1, 1'b0, 1'b0);
    waitEdges(8);
    checkFlag("R7 flag set", 1'b1);
    checkEq("R8 irq masked", {31'd0, irqReq}, 32'd0);
    busWrite(A_CTRL, ctrlWord(0, 0, 0, 0, 1, 0, 1, 1), 2'b01);
    checkFlag("R7 write 0 no effect", 1'b1);
    checkEq("R8 irq raised by enable", {31'd0, irqReq}, 32'd1);
    busWrite(A_CTRL, ctrlWord(0, 0, 0, 0, 1, 1, 1, 1), 2'b01);
    checkFlag("R7 write 1 clears", 1'b0);
    checkEq("R8 irq dropped", {31'd0, irqReq}, 32'd0);
    waitEdges(5);
    busWrite(A_CTRL, ctrlWord(0, 0, 0, 0, 1, 1, 1, 1), 2'b01);
    checkFlag("R7 clear with coincident underflow keeps flag", 1'b1);
    checkEq("R8 irq on coincident underflow", {31'd0, irqReq}, 32'd1);
    busWrite(A_CTRL, ctrlWord(0, 0, 0, 0, 1, 1, 1, 1), 2'b01);
    checkFlag("R7 later clear", 1'b0);

    // R9 enable freeze and resume
    armTimer(0, 20, 1'b0, 1'b1, 1'b0, 1'b0);
    waitEdges(6);
    checkCnt("R9 running", 17);
    busWrite(A_CTRL, ctrlWord(0, 0, 0, 0, 0, 0, 1, 0), 2'b01);
    waitEdges(10);
    checkCnt("R9 frozen while disabled", 17);
    busWrite(A_CTRL, ctrlWord(0, 0, 0, 0, 0, 0, 1, 1), 2'b01);
    waitEdges(2);
    checkCnt("R9 resumes from held count", 16);

    // R10 doze and debug halts
    dozeMode = 1'b1;
    armTimer(0, 40, 1'b0, 1'b1, 1'b1, 1'b0);
    waitEdges(10);
    checkCnt("R10 doze halt freezes", 40);
    dozeMode = 1'b0;
    debugMode = 1'b1;
    waitEdges(4);
    checkCnt("R10 debug ignored without halt bit", 38);
    busWrite(A_CTRL, ctrlWord(0, 1, 1, 0, 0, 0, 1, 1), 2'b01);
    waitEdges(6);
    checkCnt("R10 debug halt freezes", 38);
    debugMode = 1'b0;
    waitEdges(2);
    checkCnt("R10 resumes after debug", 37);

    // R11 byte lanes and read-only count
    busWrite(A_CTRL, 16'h0000, 2'b11);
    busWrite(A_MOD, 16'hABCD, 2'b11);
    busWrite(A_MOD, 16'h5612, 2'b01);
    readReg(A_MOD, v); checkEq("R11 low lane only", {16'd0, v}, 32'hAB12);
    busWrite(A_MOD, 16'h3477, 2'b10);
    readReg(A_MOD, v); checkEq("R11 high lane only", {16'd0, v}, 32'h3412);
    busWrite(A_CNT, 16'h1234, 2'b11);
    checkCnt("R11 count write ignored", 16'hFFFF);
    busWrite(A_CTRL, ctrlWord(5, 0, 0, 0, 0, 0, 0, 0), 2'b01);
    readReg(A_CTRL, v); checkEq("R6 low-byte write keeps prescaler field", {28'd0, v[11:8]}, 32'd0);

    // R2 and R5 random prescaler and modulus pairs
    for (int t = 0; t < 20; t++) begin
      int pre, m, p, k;
      pre = int'($urandom % 4);
      m = int'($urandom % 24);
      p = periodOf(m, pre);
      k = 1 + int'($urandom % (p - 1));
      armTimer(pre, m, 1'b1, 1'b1, 1'b0, 1'b0);
      checkCnt("R5 overwrite load", m);
      waitEdges(k);
      checkCnt("R2 count during period", countAfter(m, pre, k));
      waitEdges(p - 1 - k);
      checkFlag("R2 no flag before period", 1'b0);
      waitEdges(1);
      checkFlag("R2 flag at period", 1'b1);
      checkCnt("R2 reload value", m);
      busWrite(A_CTRL, ctrlWord(pre, 0, 0, 0, 1, 1, 1, 0), 2'b01);
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end
endmodule